// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a 1024-bit serial EEPROM. The storage is 64 words of 16 bits. It sits behind a Microwire-style slave port with four pins: chip select, serial clock, serial data in and serial data out. The pins are assumed to be already in the block's clock domain. The block oversamples them on `clk` and acts on each rising edge of the serial clock it detects while chip select is high.

A host frames each instruction with chip select. A frame is a start bit, a two-bit opcode, a six-bit word address and, for the two data-carrying instructions, sixteen data bits. Reads stream the addressed word back at once.

Every instruction that changes the array is only armed by its frame. It is launched by the falling edge of chip select, and only when the write-enable latch is set. The block then runs a self-timed programming interval of `PROG_CYCLES` clocks. When chip select is raised again, the data output shows ready/busy. That indication stays until the host clocks in a high bit with chip select high, which is also how the next instruction starts.

Top module: `mw_serial_eeprom`

## Requirements
- R1: After reset the block is write-disabled, idle and not busy, and the data output reads 0 when chip select is raised.
- R2: A frame starts with a 1 sampled on a rising serial-clock edge with chip select high. It continues with opcode bits (10 read, 01 word write, 11 word erase, 00 extended) and six address bits, MSB first. In the extended group the two top address bits select 11 enable, 00 disable, 01 fill-all, 10 erase-all.
- R3: On a read, the data output is 0 after the edge that samples the last address bit. Each following rising edge then presents the next bit of the word, bit 15 first.
- R4: A word write stores its sixteen data bits (first bit received is bit 15) in the addressed word.
- R5: Fill-all ignores the address bits and loads every word with its sixteen data bits.
- R6: Word erase sets the addressed word to 16'hFFFF and leaves the others untouched.
- R7: Erase-all sets every word to 16'hFFFF.
- R8: The enable instruction sets the write-enable latch and the disable instruction clears it. Write, erase, fill-all and erase-all have no effect and start no programming interval while the latch is clear.
- R9: Programming starts only on the chip-select fall that follows a complete frame. A frame cut short by chip select falling changes nothing.
- R10: A launched operation keeps the block busy for exactly PROG_CYCLES clocks. While chip select is high and the status is shown, the data output is 0 during busy and 1 afterwards.
- R11: A rising serial-clock edge that samples chip select high and data in high clears the status indication. The same edge begins decoding of a new frame.
- R12: A frame whose start bit arrives while programming is in progress is ignored entirely.
- R13: The output enable is low whenever chip select is low, one clock after chip select changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; pins are oversampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data / ready-busy status to the host |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
Two functions can land on the same serial-clock edge. One is the clearing of a shown ready indication. The other is the acceptance of a start bit, either as a new frame or, while programming is still running, as a frame to be dropped. The bench provokes both cases. First it polls until ready shows, then clocks a read frame straight in without deselecting. It judges the output dropping to 0 on the start bit and the correct word returned. Second it launches a write and at once sends another write while busy, then reads back that the second target word kept its old value.

// File: rtl/mw_pkg.sv
package mw_pkg;

  // Operations armed by a complete frame and executed on chip-select fall
  typedef enum logic [2:0] {
    CMD_WORD_WR  = 3'd0,
    CMD_FILL     = 3'd1,
    CMD_WORD_CLR = 3'd2,
    CMD_ALL_CLR  = 3'd3,
    CMD_UNLOCK   = 3'd4,
    CMD_LOCK     = 3'd5
  } mw_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR   = 3'd1,
    ST_DATA  = 3'd2,
    ST_READ  = 3'd3,
    ST_ARMED = 3'd4,
    ST_SKIP  = 3'd5
  } mw_state_e;

  // Opcode field values (frame bits right after the start bit)
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] OPC_EXT   = 2'b00;

  // Extended group selector (two top address bits)
  localparam logic [1:0] EXT_UNLOCK = 2'b11;
  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b01;
  localparam logic [1:0] EXT_ALLCLR = 2'b10;

endpackage

// File: rtl/mw_pin_front.sv
module mw_pin_front (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  output logic rst_sync_n,
  output logic cs_q,
  output logic sk_rise,
  output logic cs_fall
);

  logic [1:0] rst_pipe_q;
  logic       sk_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs_i;
      sk_q <= sk_i;
    end
  end

  assign sk_rise = sk_i & ~sk_q;
  assign cs_fall = cs_q & ~cs_i;

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [TW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start)              cnt_n = TW'(PROG_CYCLES);
    else if (cnt_q != '0)   cnt_n = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);

  // R10: a launch never overlaps a running interval
  a_r10_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt_q == '0));

  // R10: the interval counts down one per clock
  a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  mw_cmd_e           cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] wr_val;
  logic              bulk_op;
  logic              word_op;

  assign bulk_op = (cmd == CMD_FILL) || (cmd == CMD_ALL_CLR);
  assign word_op = (cmd == CMD_WORD_WR) || (cmd == CMD_WORD_CLR);
  assign wr_val  = ((cmd == CMD_WORD_WR) || (cmd == CMD_FILL)) ? data : '1;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic wr_en;
    assign wr_en = go && (bulk_op || (word_op && (addr == ADDR_W'(w))));
    // contents persist across reset, as the storage is meant to be non-volatile
    always_ff @(posedge clk) begin
      if (wr_en) mem[w] <= wr_val;
    end
  end

  assign rd_data = mem[rd_addr];

  // R7: erase-all leaves the first and last word all ones
  a_r7_all_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd == CMD_ALL_CLR) |=> ((mem[0] == '1) && (mem[WORDS-1] == '1)));

  // R5: fill-all loads the first word with the pattern
  a_r5_fill_first: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd == CMD_FILL) |=> (mem[0] == $past(data)));

endmodule

// File: rtl/mw_cmd_engine.sv
module mw_cmd_engine
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              di,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              prog_go,
  output mw_cmd_e           prog_cmd,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              status_on,
  output logic              rd_bit
);

  localparam int HDR_W = 2 + ADDR_W;
  localparam int CNT_W = $clog2((DATA_W > HDR_W) ? DATA_W : HDR_W);
  localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

  mw_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [HDR_W-2:0]  hdr_q, hdr_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  mw_cmd_e           cmd_q, cmd_n;
  logic [DATA_W:0]   rd_q, rd_n;
  logic              wen_q, wen_n;
  logic              flag_q, flag_n;
  logic [HDR_W-1:0]  frame;
  logic [1:0]        opc;
  logic [1:0]        ext;

  assign frame   = {hdr_q, di};
  assign opc     = frame[HDR_W-1 -: 2];
  assign ext     = frame[ADDR_W-1 -: 2];
  assign rd_addr = frame[ADDR_W-1:0];

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    hdr_n   = hdr_q;
    data_n  = data_q;
    addr_n  = addr_q;
    cmd_n   = cmd_q;
    rd_n    = rd_q;
    wen_n   = wen_q;
    flag_n  = flag_q;
    prog_go = 1'b0;

    if (!cs) begin
      state_n = ST_IDLE;
      rd_n    = '0;
      if (cs_fall && state_q == ST_ARMED) begin
        case (cmd_q)
          CMD_UNLOCK: wen_n = 1'b1;
          CMD_LOCK:   wen_n = 1'b0;
          default: begin
            if (wen_q && !busy) begin
              prog_go = 1'b1;
              flag_n  = 1'b1;
            end
          end
        endcase
      end
    end else if (sk_rise) begin
      case (state_q)
        ST_IDLE: begin
          if (di) begin
            flag_n  = 1'b0;
            cnt_n   = '0;
            state_n = busy ? ST_SKIP : ST_HDR;
          end
        end
        ST_HDR: begin
          hdr_n = frame[HDR_W-2:0];
          cnt_n = cnt_q + CNT_W'(1);
          if (cnt_q == LAST_HDR) begin
            cnt_n  = '0;
            addr_n = frame[ADDR_W-1:0];
            case (opc)
              OPC_READ: begin
                rd_n    = {1'b0, rd_data};
                state_n = ST_READ;
              end
              OPC_WRITE: begin
                cmd_n   = CMD_WORD_WR;
                state_n = ST_DATA;
              end
              OPC_ERASE: begin
                cmd_n   = CMD_WORD_CLR;
                state_n = ST_ARMED;
              end
              default: begin
                case (ext)
                  EXT_UNLOCK: begin cmd_n = CMD_UNLOCK;  state_n = ST_ARMED; end
                  EXT_LOCK:   begin cmd_n = CMD_LOCK;    state_n = ST_ARMED; end
                  EXT_FILL:   begin cmd_n = CMD_FILL;    state_n = ST_DATA;  end
                  default:    begin cmd_n = CMD_ALL_CLR; state_n = ST_ARMED; end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          data_n = {data_q[DATA_W-2:0], di};
          cnt_n  = cnt_q + CNT_W'(1);
          if (cnt_q == LAST_DATA) begin
            cnt_n   = '0;
            state_n = ST_ARMED;
          end
        end
        ST_READ: rd_n = {rd_q[DATA_W-1:0], 1'b0};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      data_q  <= '0;
      addr_q  <= '0;
      cmd_q   <= CMD_LOCK;
      rd_q    <= '0;
      wen_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      hdr_q   <= hdr_n;
      data_q  <= data_n;
      addr_q  <= addr_n;
      cmd_q   <= cmd_n;
      rd_q    <= rd_n;
      wen_q   <= wen_n;
      flag_q  <= flag_n;
    end
  end

  assign prog_cmd  = cmd_q;
  assign prog_addr = addr_q;
  assign prog_data = data_q;
  assign status_on = flag_q;
  assign rd_bit    = rd_q[DATA_W];

  // R8: nothing is launched with the enable latch clear
  a_r8_launch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> wen_q);

  // R11: start bit with status shown clears the status
  a_r11_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && di && sk_rise && flag_q) |=> !flag_q);

  // R12: a start bit during programming is swallowed
  a_r12_skip_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cs && di && sk_rise && busy) |=> (state_q == ST_SKIP));

  // R3: read data advances one bit per serial-clock edge
  a_r3_read_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && cs && sk_rise) |=> (rd_q[DATA_W] == $past(rd_q[DATA_W-1])));

endmodule

// File: rtl/mw_serial_eeprom.sv
module mw_serial_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);

  logic              rst_sync_n;
  logic              cs_q;
  logic              sk_rise;
  logic              cs_fall;
  logic              busy;
  logic              prog_go;
  mw_cmd_e           prog_cmd;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              status_on;
  logic              rd_bit;

  mw_pin_front u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_i       (cs_i),
    .sk_i       (sk_i),
    .rst_sync_n (rst_sync_n),
    .cs_q       (cs_q),
    .sk_rise    (sk_rise),
    .cs_fall    (cs_fall)
  );

  mw_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs        (cs_i),
    .di        (di_i),
    .sk_rise   (sk_rise),
    .cs_fall   (cs_fall),
    .busy      (busy),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .prog_go   (prog_go),
    .prog_cmd  (prog_cmd),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .status_on (status_on),
    .rd_bit    (rd_bit)
  );

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (prog_go),
    .busy  (busy)
  );

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .go      (prog_go),
    .cmd     (prog_cmd),
    .addr    (prog_addr),
    .data    (prog_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign do_oe_o = cs_q;
  assign do_o    = do_oe_o & (status_on ? ~busy : rd_bit);

  // R13: output released one clock after deselect
  a_r13_oe_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cs_i |=> !do_oe_o);

  // R9: launches coincide with a chip-select fall at the pins
  a_r9_launch_on_deselect: assert property (@(posedge clk) disable iff (!rst_sync_n)
    prog_go |-> (!cs_i && $past(cs_i)));

endmodule

// File: tb/tb_mw_serial_eeprom.sv
module tb_mw_serial_eeprom;

  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int PROG  = 300;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic do_o, do_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [WORDS];

  always #(CLK_P/2) clk = ~clk;

  mw_serial_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_i    (cs),
    .sk_i    (sk),
    .di_i    (di),
    .do_o    (do_o),
    .do_oe_o (do_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    @(negedge clk) di = b;
    @(negedge clk) sk = 1'b1;
    @(negedge clk);
    @(negedge clk) sk = 1'b0;
  endtask

  task automatic cs_on();
    @(negedge clk) cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk) begin cs = 1'b0; sk = 1'b0; di = 1'b0; end
    @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
    sk_bit(1'b1);
    for (int i = 1; i >= 0; i--) sk_bit(op[i]);
    for (int i = AW-1; i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic send_data(input logic [DW-1:0] d);
    for (int i = DW-1; i >= 0; i--) sk_bit(d[i]);
  endtask

  // assumes CS already high; header after the start bit
  task automatic read_rest(input logic [AW-1:0] a, output logic [DW-1:0] w, output logic dummy);
    sk_bit(1'b1); sk_bit(1'b0);
    for (int i = AW-1; i >= 0; i--) sk_bit(a[i]);
    dummy = do_o;
    for (int i = DW-1; i >= 0; i--) begin
      sk_bit(1'b0);
      w[i] = do_o;
    end
  endtask

  task automatic check_word(input logic [AW-1:0] a, input string req);
    logic [DW-1:0] w;
    logic dummy;
    cs_on();
    sk_bit(1'b1);
    read_rest(a, w, dummy);
    cs_off();
    chk("R3 dummy bit", {31'd0, dummy}, 32'd0);
    chk(req, {16'd0, w}, {16'd0, model[a]});
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < WORDS; a++) check_word(AW'(a), req);
  endtask

  task automatic wait_ready();
    int w;
    cs_on();
    chk("R10 busy shows 0", {31'd0, do_o}, 32'd0);
    w = 0;
    while (do_o !== 1'b1 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk("R10 busy length", w, PROG - 2);
    cs_off();
  endtask

  task automatic check_no_launch(input string req);
    nclk(PROG + 10);
    cs_on();
    chk(req, {31'd0, do_o}, 32'd0);
    cs_off();
  endtask

  task automatic op_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cs_on(); send_hdr(2'b01, a); send_data(d); cs_off();
  endtask
  task automatic op_erase(input logic [AW-1:0] a);
    cs_on(); send_hdr(2'b11, a); cs_off();
  endtask
  task automatic op_fill(input logic [DW-1:0] d);
    cs_on(); send_hdr(2'b00, 6'b01_0110); send_data(d); cs_off();
  endtask
  task automatic op_allclr();
    cs_on(); send_hdr(2'b00, 6'b10_1001); cs_off();
  endtask
  task automatic op_wen();
    cs_on(); send_hdr(2'b00, 6'b11_0000); cs_off();
  endtask
  task automatic op_wds();
    cs_on(); send_hdr(2'b00, 6'b00_1111); cs_off();
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 1031) ^ 16'hA55A;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    logic dummy;
    int cnt;

    // R1 / R13: reset state
    nclk(4);
    chk("R13 oe low in reset", {31'd0, do_oe}, 32'd0);
    chk("R1 do low in reset", {31'd0, do_o}, 32'd0);
    rst_n = 1'b1;
    nclk(5);
    cs_on();
    chk("R13 oe high with cs", {31'd0, do_oe}, 32'd1);
    chk("R1 no status after reset", {31'd0, do_o}, 32'd0);
    cs_off();
    chk("R13 oe low after cs", {31'd0, do_oe}, 32'd0);

    // R7: erase-all, exhaustive readback
    op_wen();
    op_allclr();
    wait_ready();
    for (int a = 0; a < WORDS; a++) model[a] = 16'hFFFF;
    sweep("R7 erase-all word");

    // R5: fill-all with address bits ignored
    op_fill(16'h5AC3);
    wait_ready();
    for (int a = 0; a < WORDS; a++) model[a] = 16'h5AC3;
    sweep("R5 fill-all word");

    // R4 / R2: every word written with a computed pattern
    for (int a = 0; a < WORDS; a++) begin
      op_write(AW'(a), pat(a));
      wait_ready();
      model[a] = pat(a);
    end
    sweep("R4 word write");

    // R6: erase odd words only
    for (int a = 1; a < WORDS; a += 2) begin
      op_erase(AW'(a));
      wait_ready();
      model[a] = 16'hFFFF;
    end
    sweep("R6 word erase");

    // R8: disable blocks every programming instruction
    op_wds();
    op_write(6'd2, 16'h0000);
    check_no_launch("R8 write while disabled");
    op_erase(6'd4);
    check_no_launch("R8 erase while disabled");
    op_allclr();
    check_no_launch("R8 erase-all while disabled");
    op_fill(16'h0F0F);
    check_no_launch("R8 fill while disabled");
    check_word(6'd2, "R8 word 2 kept");
    check_word(6'd4, "R8 word 4 kept");
    check_word(6'd9, "R8 word 9 kept");

    // R1 / R8: a fresh reset leaves the latch clear
    op_wen();
    @(negedge clk) rst_n = 1'b0;
    nclk(3);
    rst_n = 1'b1;
    nclk(5);
    op_write(6'd6, 16'h0000);
    check_no_launch("R1 disabled after reset");
    check_word(6'd6, "R1 word 6 kept");

    // R9: frames cut short change nothing
    op_wen();
    cs_on();
    sk_bit(1'b1); sk_bit(1'b1); sk_bit(1'b1);
    for (int i = AW-1; i >= 1; i--) sk_bit(6'd6 >> i);
    cs_off();
    check_no_launch("R9 short erase not launched");
    check_word(6'd6, "R9 word 6 after short erase");
    cs_on();
    send_hdr(2'b01, 6'd8);
    for (int i = DW-1; i >= 1; i--) sk_bit(1'b0);
    cs_off();
    check_no_launch("R9 short write not launched");
    check_word(6'd8, "R9 word 8 after short write");

    // R12: a second write while busy is dropped
    op_write(6'd10, 16'h1111);
    model[10] = 16'h1111;
    op_write(6'd12, 16'h2222);
    nclk(PROG + 20);
    check_word(6'd10, "R12 launched write stored");
    check_word(6'd12, "R12 busy-time write ignored");

    // R11: start bit clears the ready indication and starts a read
    op_write(6'd14, 16'hBEEF);
    model[14] = 16'hBEEF;
    cs_on();
    cnt = 0;
    while (do_o !== 1'b1 && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    chk("R10 ready shown", {31'd0, do_o}, 32'd1);
    sk_bit(1'b1);
    chk("R11 status cleared", {31'd0, do_o}, 32'd0);
    read_rest(6'd14, w, dummy);
    cs_off();
    chk("R11 read after clear", {16'd0, w}, {16'd0, model[14]});
    chk("R3 dummy after clear", {31'd0, dummy}, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule